// File: doc/BRIEF.md
# Byte-Serial Substitution Round Engine

This block carries out one round of a 128-bit substitution-permutation cipher, handling one byte per active cycle. The 16-byte state sits in a small two-bank store laid out as a 4x4 byte array, column-major, so that byte index = 4*column + row. For each destination byte the engine reads the source byte, passes it through the AES substitution box, XORs in the next round-key byte, and writes the result into the opposite bank. The row rotation (row k moves left by k columns) is done only by choosing the read address. At the end of the round the banks swap roles, and the new state becomes the one that the host port sees.

Round-key bytes arrive on a byte-wide valid/ready input. A missing key byte stalls the engine for that cycle and changes nothing else. The order of operations never depends on key or data values. A start pulse begins a round and a one-cycle done pulse ends it. A final-round flag, captured at start, tells a separate column-mixing unit whether it should run next. Key expansion and column mixing are outside this block. While the engine is idle, a host port loads and reads back the state.

Top module: `byte_round_engine`

## Requirements
- R1: After reset, `done`, `mix_go`, `key_ready` and `busy` are all low.
- R2: While `busy` is low, a write with `host_we` high stores `host_wdata` at byte `host_addr`. `host_rdata` always shows, combinationally, the byte at `host_addr` in the current state.
- R3: A `start` sampled while idle raises `busy` and `key_ready` on the next cycle. A `start` sampled while busy has no effect.
- R4: Let destination byte d = 4*c + r. Its new value is S(old[4*((c + r) mod 4) + r]) XOR k_d, where k_d is the d-th key byte accepted in the round (d = 0..15).
- R5: S is the AES substitution box: the multiplicative inverse in GF(2^8) modulo x^8+x^4+x^3+x+1, followed by the affine map with constant 0x63. For example S(0x00)=0x63, S(0x01)=0x7c, S(0x53)=0xed, S(0xff)=0x16.
- R6: A key byte is consumed only on a clock edge where `key_valid` and `key_ready` are both high. Exactly 16 bytes are consumed per round. A cycle with `key_valid` low leaves the byte position unchanged and does not alter the result.
- R7: `done` is high for exactly one cycle, and `key_ready` is low during that cycle. With no stalls, `done` is seen 16 cycles after the cycle in which `start` was sampled. Each stall cycle adds exactly one cycle.
- R8: During the `done` cycle, `mix_go` equals the inverse of the `final_round` value sampled with `start`. Changes to `final_round` later in the round have no effect. `mix_go` is never high without `done`.
- R9: Host writes while `busy` is high are ignored.
- R10: After `done`, the host port shows the new state, and the next round starts from that state without a reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a round (sampled while idle) |
| final_round | input | 1 | Round skips column mixing (sampled with start) |
| key_valid | input | 1 | Round-key byte on key_data is valid |
| key_data | input | 8 | Round-key byte |
| key_ready | output | 1 | Engine can take a key byte this cycle |
| done | output | 1 | One-cycle end-of-round pulse |
| mix_go | output | 1 | Column unit should run after this round |
| busy | output | 1 | Round in progress |
| host_we | input | 1 | Host state write enable |
| host_addr | input | 4 | Host byte index (4*column + row) |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | State byte at host_addr |

## Verification
Some properties are checked by assertions on every cycle:
- `done` lasts a single cycle.
- Exactly sixteen key bytes have been accepted when `done` rises.
- A stall cycle keeps the byte position.
- `mix_go` appears only together with `done`.
- The visible state cannot change while a round is running.

Other behaviour shows up only in the bench scenarios, where results are compared against a separately built substitution table and a row-rotation model:
- The byte values themselves and the exact cross-column routing.
- Chaining of rounds through the bank swap.
- Cycle counts under random stall patterns.
- Ignoring of `start`, `final_round` and host writes during a round.

// File: rtl/rnd_pkg.sv
package rnd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } eng_state_e;

  // GF(2^8) product modulo x^8+x^4+x^3+x+1
  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = {sh[6:0], 1'b0} ^ (sh[7] ? 8'h1b : 8'h00);
    end
    return acc;
  endfunction

  // inverse as x^254 = x^2 * x^4 * ... * x^128 (zero maps to zero)
  function automatic logic [7:0] gf_inv(input logic [7:0] x);
    logic [7:0] sq;
    logic [7:0] res;
    sq  = x;
    res = 8'h01;
    for (int i = 1; i < 8; i++) begin
      sq  = gf_mul(sq, sq);
      res = gf_mul(res, sq);
    end
    return res;
  endfunction

  function automatic logic [7:0] sub_byte(input logic [7:0] x);
    logic [7:0] b;
    b = gf_inv(x);
    return b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]}
             ^ {b[3:0], b[7:4]} ^ 8'h63;
  endfunction

endpackage

// File: rtl/rnd_sbox.sv
module rnd_sbox (
  input  logic [7:0] in_byte,
  output logic [7:0] out_byte
);
  import rnd_pkg::*;

  always_comb begin
    out_byte = sub_byte(in_byte);
  end

endmodule

// File: rtl/rnd_addr_gen.sv
module rnd_addr_gen #(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  localparam int RW  = $clog2(ROWS),
  localparam int CW  = $clog2(COLS),
  localparam int AW  = RW + CW
) (
  input  logic [AW-1:0] dst_idx,
  output logic [AW-1:0] src_idx
);
  logic [RW-1:0] row;
  logic [CW-1:0] dst_col;
  logic [CW-1:0] src_col;

  // row r of the result takes its byte from column (c + r) mod COLS
  always_comb begin
    row     = dst_idx[RW-1:0];
    dst_col = dst_idx[AW-1:RW];
    src_col = dst_col + CW'(row);
    src_idx = {src_col, row};
  end

endmodule

// File: rtl/rnd_state_bank.sv
module rnd_state_bank #(
  parameter int NB = 16,
  localparam int AW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          eng_busy,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [7:0]    host_wdata,
  output logic [7:0]    host_rdata,
  input  logic [AW-1:0] eng_raddr,
  output logic [7:0]    eng_rdata,
  input  logic          eng_we,
  input  logic [AW-1:0] eng_waddr,
  input  logic [7:0]    eng_wdata,
  input  logic          swap
);
  logic       sel_q;
  logic       sel_d;
  logic       host_ok;
  logic [7:0] host_rd_b [2];
  logic [7:0] eng_rd_b  [2];

  assign host_ok = host_we && !eng_busy;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [7:0]    mem [NB];
    logic          we;
    logic [AW-1:0] waddr;
    logic [7:0]    wdata;
    logic          is_cur;

    assign is_cur = (sel_q == 1'(b));
    // the current bank takes host writes, the other one takes engine results
    assign we     = is_cur ? host_ok   : eng_we;
    assign waddr  = is_cur ? host_addr : eng_waddr;
    assign wdata  = is_cur ? host_wdata : eng_wdata;

    always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
    end

    assign host_rd_b[b] = mem[host_addr];
    assign eng_rd_b[b]  = mem[eng_raddr];
  end

  assign host_rdata = host_rd_b[sel_q];
  assign eng_rdata  = eng_rd_b[sel_q];

  always_comb begin
    sel_d = sel_q;
    if (swap) sel_d = ~sel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= 1'b0;
    else        sel_q <= sel_d;
  end

  // visible state is frozen for the whole round (R9)
  p_host_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_busy && $past(eng_busy) && $stable(host_addr)) |-> $stable(host_rdata));

endmodule

// File: rtl/byte_round_engine.sv
module byte_round_engine #(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  localparam int NB  = ROWS * COLS,
  localparam int AW  = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          final_round,
  input  logic          key_valid,
  input  logic [7:0]    key_data,
  output logic          key_ready,
  output logic          done,
  output logic          mix_go,
  output logic          busy,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [7:0]    host_wdata,
  output logic [7:0]    host_rdata
);
  import rnd_pkg::*;

  logic [1:0]    rst_sync_q;
  logic          rst_i_n;
  eng_state_e    state_q, state_d;
  logic [AW-1:0] cnt_q, cnt_d;
  logic          final_q, final_d;
  logic          accept;
  logic          swap;
  logic [AW-1:0] src_idx;
  logic [7:0]    rd_byte;
  logic [7:0]    sub_out;
  logic [7:0]    wr_byte;
  logic [AW:0]   acc_seen_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  assign accept    = (state_q == ST_RUN) && key_valid;
  assign key_ready = (state_q == ST_RUN);
  assign busy      = (state_q != ST_IDLE);
  assign done      = (state_q == ST_FIN);
  assign mix_go    = done && !final_q;
  assign swap      = done;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    final_d = final_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_RUN;
          cnt_d   = '0;
          final_d = final_round;
        end
      end
      ST_RUN: begin
        if (accept) begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == AW'(NB - 1)) state_d = ST_FIN;
        end
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      final_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      final_q <= final_d;
    end
  end

  rnd_addr_gen #(.ROWS(ROWS), .COLS(COLS)) i_addr (
    .dst_idx (cnt_q),
    .src_idx (src_idx)
  );

  rnd_sbox i_sbox (
    .in_byte  (rd_byte),
    .out_byte (sub_out)
  );

  assign wr_byte = sub_out ^ key_data;

  rnd_state_bank #(.NB(NB)) i_bank (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .eng_busy   (busy),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .eng_raddr  (src_idx),
    .eng_rdata  (rd_byte),
    .eng_we     (accept),
    .eng_waddr  (cnt_q),
    .eng_wdata  (wr_byte),
    .swap       (swap)
  );

  // accepted-byte tally used only by the checks below
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)                acc_seen_q <= '0;
    else if (state_q == ST_IDLE) acc_seen_q <= '0;
    else if (accept)             acc_seen_q <= acc_seen_q + 1'b1;
  end

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_i_n)
    done |=> !done);

  p_full_round_r6: assert property (@(posedge clk) disable iff (!rst_i_n)
    done |-> (acc_seen_q == (AW+1)'(NB)));

  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_i_n)
    (key_ready && !key_valid) |=> ($stable(cnt_q) && key_ready));

  p_mix_with_done_r8: assert property (@(posedge clk) disable iff (!rst_i_n)
    mix_go |-> (done && !key_ready));

  p_start_kicks_r3: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!busy && start) |=> (busy && key_ready));

endmodule

// File: tb/test_byte_round_engine.sv
module test_byte_round_engine;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 50000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       final_round = 1'b0;
  logic       key_valid = 1'b0;
  logic [7:0] key_data = 8'h00;
  logic       key_ready, done, mix_go, busy;
  logic       host_we = 1'b0;
  logic [3:0] host_addr = 4'h0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;

  logic [7:0] sb  [256];
  logic [7:0] st  [16];
  logic [7:0] key [16];
  logic [7:0] exp_st [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  byte_round_engine i_byte_round_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .final_round(final_round),
    .key_valid(key_valid), .key_data(key_data), .key_ready(key_ready),
    .done(done), .mix_go(mix_go), .busy(busy), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT) begin
      fails++;
      tests++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < %0d", cyc, WD_LIMIT);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int expv);
    tests++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, expv);
    end
  endtask

  // table from powers of the generator 3 (log/antilog), then the affine map
  function automatic void build_sbox();
    logic [7:0] alog [256];
    int         lg   [256];
    logic [7:0] p;
    logic [7:0] inv;
    p = 8'h01;
    for (int i = 0; i < 255; i++) begin
      alog[i] = p;
      lg[p]   = i;
      p = p ^ ({p[6:0], 1'b0} ^ (p[7] ? 8'h1b : 8'h00));
    end
    for (int x = 0; x < 256; x++) begin
      if (x == 0) inv = 8'h00;
      else        inv = alog[(255 - lg[x]) % 255];
      sb[x] = inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
            ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
    end
  endfunction

  function automatic void model_round();
    for (int d = 0; d < 16; d++) begin
      int r, c, sc;
      r  = d % 4;
      c  = d / 4;
      sc = (c + r) % 4;
      exp_st[d] = sb[st[sc*4 + r]] ^ key[d];
    end
  endfunction

  task automatic load_state();
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      host_we = 1'b1; host_addr = 4'(i); host_wdata = st[i];
    end
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic read_check(input string tag);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      host_addr = 4'(i);
      #1;
      check(tag, host_rdata, exp_st[i]);
    end
  endtask

  // runs one round; stall_pct is the chance of key_valid low; noise drives
  // start, final_round and host writes during the round
  task automatic run_round(input logic fin, input int stall_pct, input logic noise);
    int idx, iters, stalls;
    logic acc, got_done;
    model_round();
    @(negedge clk);
    start = 1'b1; final_round = fin;
    @(negedge clk);
    start = 1'b0;
    check("R3 key_ready after start", key_ready, 1);
    check("R3 busy after start", busy, 1);
    idx = 0; iters = 0; stalls = 0; got_done = 1'b0;
    while (!got_done && iters < 400) begin
      if (idx < 16) begin
        key_valid = (($urandom % 100) >= stall_pct);
        key_data  = key[idx];
      end else begin
        key_valid = 1'b0;
      end
      if (noise) begin
        host_we = 1'($urandom); host_addr = 4'($urandom);
        host_wdata = 8'($urandom); start = 1'($urandom);
        final_round = 1'($urandom);
      end
      acc = key_valid && key_ready;
      if (!acc) stalls++;
      @(negedge clk);
      iters++;
      if (acc) idx++;
      if (done) got_done = 1'b1;
    end
    key_valid = 1'b0; host_we = 1'b0; start = 1'b0;
    check("R7 done reached", got_done, 1);
    check("R6 bytes accepted", idx, 16);
    check("R7 cycle count", iters, 16 + stalls);
    check("R8 mix_go", mix_go, !fin);
    check("R7 key_ready low at done", key_ready, 0);
    @(negedge clk);
    check("R7 done single pulse", done, 0);
    check("R8 mix_go cleared", mix_go, 0);
    check("R3 start ignored while busy", busy, 0);
    read_check(noise ? "R9 R4 result under noise" : "R4 result");
    for (int i = 0; i < 16; i++) st[i] = exp_st[i];
  endtask

  initial begin
    void'($urandom(32'h5eed_0017));
    build_sbox();
    check("R5 bench table 00", sb[8'h00], 8'h63);
    check("R5 bench table 53", sb[8'h53], 8'hed);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 done", done, 0);
    check("R1 mix_go", mix_go, 0);
    check("R1 key_ready", key_ready, 0);
    check("R1 busy", busy, 0);

    // R2 host load and readback
    for (int i = 0; i < 16; i++) st[i] = 8'($urandom);
    load_state();
    for (int i = 0; i < 16; i++) exp_st[i] = st[i];
    read_check("R2 readback");

    // R5 R4 directed: known S-box points routed across columns, zero key
    for (int i = 0; i < 16; i++) begin st[i] = 8'h00; key[i] = 8'h00; end
    st[0] = 8'h01; st[5] = 8'h53; st[15] = 8'hff;
    load_state();
    run_round(1'b1, 0, 1'b0);
    @(negedge clk); host_addr = 4'd0; #1; check("R5 S(01)", host_rdata, 8'h7c);
    @(negedge clk); host_addr = 4'd1; #1; check("R5 R4 S(53) row1 shift", host_rdata, 8'hed);
    @(negedge clk); host_addr = 4'd3; #1; check("R5 R4 S(ff) row3 shift", host_rdata, 8'h16);
    @(negedge clk); host_addr = 4'd2; #1; check("R5 S(00)", host_rdata, 8'h63);

    // R10 chained random rounds with stalls, R9 R8 R3 noise on some
    for (int n = 0; n < 8; n++) begin
      for (int i = 0; i < 16; i++) key[i] = 8'($urandom);
      if (n == 4) begin
        for (int i = 0; i < 16; i++) st[i] = 8'($urandom);
        load_state();
      end
      run_round(1'(n % 2), (n % 3) * 35, 1'(n > 1 && (n % 2 == 0)));
    end

    // R6 heavy stall, R10 continues from previous state
    for (int i = 0; i < 16; i++) key[i] = 8'(i * 17 + 3);
    run_round(1'b0, 85, 1'b1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule